// File: doc/BRIEF.md
# Horizontal Reduction Sequencer

This block folds groups of adjacent fields of a 128-bit register into one value per group, using a single operator chosen per request: add, bitwise or, bitwise and, or unsigned minimum. It has no reduction tree. Each clock cycle it performs one pairwise step. In a step, every field of the current width is split into its upper and lower halves. The two halves are combined with the operator, and the outcome is zero-extended back into the full field. The field width doubles after every step, so a group of 2^h fields needs exactly h steps.

A request supplies four values and a one-cycle start pulse: the starting field width as a log2 code, the group exponent h, the operator and the source register. The FSM has three states. `S_IDLE` waits for start. `S_STEP` applies one doubling step per cycle. `S_FINISH` raises done for one cycle. The transitions are:

- `S_IDLE` goes to `S_STEP` on start when the effective h is nonzero, and to `S_FINISH` on start when the effective h is zero.
- `S_STEP` stays in `S_STEP` while more than one step remains, and goes to `S_FINISH` after the last step.
- `S_FINISH` always returns to `S_IDLE`.

A request whose final field would be wider than the register is clamped and flagged.

Top module: `hred_seq`

## Requirements
- R1: A start sampled at rising edge E0 in idle, with effective exponent h, makes done high for exactly one cycle, the cycle after edge E(h). busy is high from just after E0 through that done cycle, and low otherwise.
- R2: Field width is 2^start_lg bits (start_lg 0..7). Operator codes are 0 add, 1 or, 2 and, 3 unsigned minimum. When done is high, result holds each group's reduction of its 2^h source fields in the low bits of a field of width 2^start_lg·2^h. All bits above the reduction in each such field are zero.
- R3: For add, no carry is lost. The result equals the full sum of the group's fields, for example 16 byte fields of 0xFF giving 4080.
- R4: With h = 0, result equals the source unchanged, and done is high in the cycle right after the start edge.
- R5: A start pulse arriving while busy is high is ignored. The running request finishes with its own operands, and no extra done follows.
- R6: If start_lg + h exceeds 7, h is clamped to 7 − start_lg and clamp_err is high together with done. clamp_err is low at all other times.
- R7: While idle with start low, result holds its last value whatever the other inputs do.
- R8: After reset, busy, done and clamp_err are low and result is zero.
- R9: An or-across of four 32-bit fields (start_lg 5, h 2) completes with done in the cycle after the second step edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request pulse |
| start_lg | input | 3 | log2 of the starting field width |
| grp_h | input | 3 | log2 of the number of fields per group |
| op | input | 2 | Operator code (0 add, 1 or, 2 and, 3 min) |
| src | input | 128 | Source register |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| clamp_err | output | 1 | Exponent was clamped (valid with done) |
| result | output | 128 | Reduced register |

## Verification
The assertions check the following on every cycle:
- done lasts one cycle and only ever appears while busy is high.
- busy never drops except straight after done.
- clamp_err appears only with done.
- A zero-exponent start is answered on the next cycle.
- result stays frozen while idle.

Only the bench scenarios can show that the reduced values are correct. They also show the exact step count for each h, the clamping of oversized requests, and that a second start during a run leaves that run's result intact. These checks rely on a reference model that reduces each group directly rather than step by step.

// File: rtl/hred_pkg.sv
package hred_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_OR  = 2'd1,
        OP_AND = 2'd2,
        OP_MIN = 2'd3
    } red_op_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_STEP   = 2'd1,
        S_FINISH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/hred_lane.sv
// One half-operand combine: upper half against lower half, zero-extended.
module hred_lane
    import hred_pkg::*;
#(
    parameter int HW = 1
) (
    input  logic [HW-1:0]   hi,
    input  logic [HW-1:0]   lo,
    input  red_op_e         op,
    output logic [2*HW-1:0] y
);
    localparam int FW = 2 * HW;

    logic [HW:0] sum;
    assign sum = {1'b0, hi} + {1'b0, lo};

    always_comb begin
        unique case (op)
            OP_ADD: y = FW'(sum);
            OP_OR:  y = FW'(hi | lo);
            OP_AND: y = FW'(hi & lo);
            OP_MIN: y = FW'((hi < lo) ? hi : lo);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/hred_step.sv
// Behavioural half-modifier ALU: one doubling step at a selectable width.
module hred_step
    import hred_pkg::*;
#(
    parameter int REG_W  = 128,
    parameter int LG_REG = $clog2(REG_W),
    parameter int CW     = $clog2(LG_REG + 1)
) (
    input  logic [REG_W-1:0] v,
    input  red_op_e          op,
    input  logic [CW-1:0]    lg_next,
    output logic [REG_W-1:0] y
);
    logic [REG_W-1:0] cand [1:LG_REG];

    for (genvar L = 1; L <= LG_REG; L++) begin : g_width
        localparam int FW = 1 << L;
        localparam int HW = FW / 2;
        localparam int NF = REG_W / FW;
        for (genvar f = 0; f < NF; f++) begin : g_field
            hred_lane #(.HW(HW)) u_lane (
                .hi (v[f*FW+HW +: HW]),
                .lo (v[f*FW +: HW]),
                .op (op),
                .y  (cand[L][f*FW +: FW])
            );
        end
    end

    always_comb begin
        y = v;
        for (int L = 1; L <= LG_REG; L++) begin
            if (lg_next == CW'(L)) y = cand[L];
        end
    end
endmodule

// File: rtl/hred_seq.sv
module hred_seq
    import hred_pkg::*;
#(
    parameter int REG_W  = 128,
    parameter int LG_REG = $clog2(REG_W),
    parameter int CW     = $clog2(LG_REG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CW-1:0]    start_lg,
    input  logic [CW-1:0]    grp_h,
    input  logic [1:0]       op,
    input  logic [REG_W-1:0] src,
    output logic             busy,
    output logic             done,
    output logic             clamp_err,
    output logic [REG_W-1:0] result
);
    localparam logic [CW-1:0] LG_MAX = CW'(LG_REG);

    seq_state_e state_q, state_d;

    logic [REG_W-1:0] acc_q;
    logic [CW-1:0]    lg_q, left_q;
    red_op_e          op_q;
    logic             err_q;

    logic [CW-1:0]    lg_eff, h_max, h_eff;
    logic             over;
    logic [REG_W-1:0] step_y;
    logic             accept;

    // request legalisation
    always_comb begin
        lg_eff = (start_lg > LG_MAX) ? LG_MAX : start_lg;
        h_max  = LG_MAX - lg_eff;
        over   = (grp_h > h_max);
        h_eff  = over ? h_max : grp_h;
    end

    assign accept = (state_q == S_IDLE) && start;

    hred_step #(.REG_W(REG_W), .LG_REG(LG_REG), .CW(CW)) u_step (
        .v       (acc_q),
        .op      (op_q),
        .lg_next (lg_q + CW'(1)),
        .y       (step_y)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = (h_eff == '0) ? S_FINISH : S_STEP;
            S_STEP:   if (left_q == CW'(1)) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // running register and step bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            lg_q   <= '0;
            left_q <= '0;
            op_q   <= OP_ADD;
            err_q  <= 1'b0;
        end else if (accept) begin
            acc_q  <= src;
            lg_q   <= lg_eff;
            left_q <= h_eff;
            op_q   <= red_op_e'(op);
            err_q  <= over;
        end else if (state_q == S_STEP) begin
            acc_q  <= step_y;
            lg_q   <= lg_q + CW'(1);
            left_q <= left_q - CW'(1);
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_FINISH);
        clamp_err = (state_q == S_FINISH) && err_q;
        result    = acc_q;
    end
endmodule

// File: rtl/hred_seq_chk.sv
module hred_seq_chk #(
    parameter int REG_W = 128,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CW-1:0]    grp_h,
    input logic             busy,
    input logic             done,
    input logic             clamp_err,
    input logic [REG_W-1:0] result
);
    p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_busy_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_busy_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_h0_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && grp_h == '0) |=> done);

    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_err |-> done);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));
endmodule

bind hred_seq hred_seq_chk #(.REG_W(REG_W), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .grp_h     (grp_h),
    .busy      (busy),
    .done      (done),
    .clamp_err (clamp_err),
    .result    (result)
);

// File: tb/tb_hred_seq.sv
module tb_hred_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   start_lg = '0;
    logic [2:0]   grp_h = '0;
    logic [1:0]   op = '0;
    logic [127:0] src = '0;
    logic         busy, done, clamp_err;
    logic [127:0] result;

    int checks = 0;
    int failures = 0;
    int dones = 0;
    int cyc = 0;

    typedef struct {
        logic [127:0] res;
        logic         err;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    hred_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_lg(start_lg),
        .grp_h(grp_h), .op(op), .src(src), .busy(busy), .done(done),
        .clamp_err(clamp_err), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] ref_red(input logic [1:0] o, input int lg, input int he,
                                             input logic [127:0] s);
        int w, n, gw;
        logic [127:0] m, r, a, f;
        w = 1 << lg;
        n = 1 << he;
        gw = w * n;
        m = (w >= 128) ? '1 : ((128'd1 << w) - 128'd1);
        r = '0;
        for (int g = 0; g < 128 / gw; g++) begin
            a = (s >> (g * gw)) & m;
            for (int k = 1; k < n; k++) begin
                f = (s >> (g * gw + k * w)) & m;
                case (o)
                    2'd0: a = a + f;
                    2'd1: a = a | f;
                    2'd2: a = a & f;
                    default: a = (f < a) ? f : a;
                endcase
            end
            r = r | (a << (g * gw));
        end
        return r;
    endfunction

    // monitor: pops the scoreboard on every done
    always @(negedge clk) begin
        if (rst_n && done) begin
            dones++;
            if (sb.size() == 0) begin
                chk(1'b0, "R5 unexpected done", result, '0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(result == e.res, e.tag, result, e.res);
                chk(clamp_err == e.err, {e.tag, " R6 err"}, 128'(clamp_err), 128'(e.err));
            end
        end
    end

    // driver: issues one request, optionally a stray start while busy
    task automatic run(input logic [1:0] o, input int lg, input int h, input logic [127:0] s,
                       input string tag, input bit stray);
        int he, hmax, k, d0;
        exp_t e;
        hmax = 7 - lg;
        he = (h > hmax) ? hmax : h;
        e.res = ref_red(o, lg, he, s);
        e.err = (h > hmax);
        e.tag = tag;
        sb.push_back(e);
        d0 = dones;
        @(negedge clk);
        op = o; start_lg = 3'(lg); grp_h = 3'(h); src = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 40) begin
            if (stray && k == 0) begin
                src = ~s; op = ~o; grp_h = 3'd0; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            k++;
        end
        chk(k == he, {tag, " R1 latency"}, 128'(k), 128'(he));
        repeat (3) @(negedge clk);
        chk(dones == d0 + 1, {tag, " R5 done count"}, 128'(dones - d0), 128'd1);
    endtask

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !clamp_err && result == '0, "R8 reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 / R2: or-across of four 32-bit fields
        run(2'd1, 5, 2, 128'h0000_0001_0000_0020_0400_0000_8000_0000, "R9 or32x4", 1'b0);
        run(2'd0, 3, 3, {16{8'hFF}}, "R3 add8x8", 1'b0);
        run(2'd0, 3, 4, {16{8'hFF}}, "R3 add8x16", 1'b0);
        run(2'd2, 4, 2, 128'hFFFF_F0FF_FF7F_FFFF_1234_FFFF_FFF8_FFFF, "R2 and16x4", 1'b0);
        run(2'd3, 3, 4, 128'h90A1_B2C3_D4E5_F607_1829_3A4B_5C6D_7E8F, "R2 min8x16", 1'b0);
        run(2'd3, 4, 1, 128'h0005_0003_FFFF_0000_8000_7FFF_1111_2222, "R2 min16x2", 1'b0);
        run(2'd0, 0, 7, 128'hF0F0_0000_1234_5678_9ABC_DEF0_FFFF_0001, "R3 add1x128", 1'b0);
        run(2'd1, 2, 0, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_CAFE_F00D, "R4 passthrough", 1'b0);
        run(2'd0, 5, 5, 128'h0000_0010_0000_0020_0000_0030_0000_0040, "R6 clamp", 1'b0);
        run(2'd0, 4, 3, 128'h0001_0002_0003_0004_0005_0006_0007_0008, "R5 stray start", 1'b1);

        // R7: idle hold while inputs wander
        held = result;
        src = '1; op = 2'd2; start_lg = 3'd1; grp_h = 3'd6;
        repeat (4) @(negedge clk);
        chk(result == held && !busy, "R7 idle hold", result, held);

        chk(sb.size() == 0, "R1 pending items", 128'(sb.size()), 128'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule